// File: doc/BRIEF.md
# Write Completion Status Responder

This block sits on the read side of a byte-wide nonvolatile memory whose writes finish in a long internal programming cycle. It chooses what a host read returns. While the programming timer reports busy, a read does not return array contents. It returns a status byte instead. Bit 7 is the inverse of bit 7 of the most recent byte written. Bit 6 flips on every new read access. Bits 5 to 0 are zero. When busy clears, the toggling stops and reads return the array data again.

A read access is in progress while the active-low chip select and the active-low output enable are both low. The block keeps its own copy of the last byte written and a toggle flip-flop. It registers its output once, so data and the drive flag appear one clock after the inputs that cause them. The pad tri-state is left to the surrounding logic, which uses the drive flag.

The block decides between a status read and a true read once, in the first cycle of an access, and keeps that choice until the access ends. Neither the write-load path nor the read path has back-pressure: the block accepts a byte on every cycle that `wr_load_i` is high and produces a read result on every cycle of an access, so there is no valid/ready pair and every pin is a plain control or data pin.

Top module: `wcs_responder`

## Requirements
- R1: After reset `rd_drive_o` and `rd_data_o` are 0, and the toggle flip-flop is 0, so the first status read after reset shows bit 6 = 1.
- R2: `rd_drive_o` is 1 in the cycle after a cycle with `ce_n_i`=0 and `oe_n_i`=0, and 0 otherwise. When `rd_drive_o` is 0, `rd_data_o` is 0.
- R3: In a true read, `rd_data_o` equals `array_data_i` from the previous cycle.
- R4: In a status read, `rd_data_o[7]` is the inverse of bit 7 of the last byte loaded.
- R5: In a status read, `rd_data_o[6]` holds the toggle value, and the toggle inverts at the start of each new status read.
- R6: In a status read, `rd_data_o[5:0]` is 0.
- R7: The toggle changes only on the first cycle of an access. Holding the strobe for many cycles keeps bit 6 stable.
- R8: The mode is fixed in the first cycle of an access: status if `busy_i`=1 in that cycle, true data otherwise. If busy falls during an access, that access still returns status, and the next access returns true data.
- R9: The stored last byte is the `wr_byte_i` value of the most recent cycle with `wr_load_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy_i | input | 1 | Internal programming cycle in progress |
| wr_load_i | input | 1 | A byte write is being accepted this cycle |
| wr_byte_i | input | 8 | Byte being written |
| ce_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output enable, active low |
| array_data_i | input | 8 | Data read from the array |
| rd_data_o | output | 8 | Read result (registered) |
| rd_drive_o | output | 1 | Read bus should be driven (registered) |

## Verification
The in-RTL assertions check, on every cycle, several relations:
- the drive flag follows the strobe one cycle later;
- the reserved bits are zero and bit 7 is inverted on status reads;
- true reads pass the array data;
- the toggle moves only at the start of a status access;
- the stored byte follows the last load.

Some properties come only from the bench's scenarios:
- the toggle sequence across several separate reads;
- a read that stays in status after busy falls in the middle of it;
- the value of the first toggle after reset.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_TRUE   = 2'd1,
    MODE_STATUS = 2'd2
  } rd_mode_e;
endpackage

// File: rtl/wcs_strobe_track.sv
module wcs_strobe_track
  import wcs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ce_n_i,
  input  logic     oe_n_i,
  input  logic     busy_i,
  output logic     rd_act_o,
  output logic     rd_start_o,
  output rd_mode_e mode_o
);
  logic     act_q;
  rd_mode_e mode_q;

  assign rd_act_o   = !ce_n_i && !oe_n_i;
  assign rd_start_o = rd_act_o && !act_q;

  always_comb begin
    if (!rd_act_o)       mode_o = MODE_IDLE;
    else if (rd_start_o) mode_o = busy_i ? MODE_STATUS : MODE_TRUE;
    else                 mode_o = mode_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      mode_q <= MODE_IDLE;
    end else begin
      act_q  <= rd_act_o;
      mode_q <= mode_o;
    end
  end

  // A status access keeps its mode while the strobe stays low
  assert_mode_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_STATUS) |=> (!rd_act_o || mode_o == MODE_STATUS));
  assert_start_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start_o |=> !rd_start_o);
endmodule

// File: rtl/wcs_last_byte.sv
module wcs_last_byte #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [DATA_W-1:0] last_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      last_o <= '0;
    else if (load_i) last_o <= byte_i;
  end

  assert_last_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> last_o == $past(byte_i));
  assert_last_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(last_o));
endmodule

// File: rtl/wcs_toggle.sv
module wcs_toggle
  import wcs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rd_start_i,
  input  logic     rd_act_i,
  input  rd_mode_e mode_i,
  output logic     tog_o
);
  logic tog_q;
  logic advance;

  assign advance = rd_start_i && (mode_i == MODE_STATUS);
  assign tog_o   = tog_q ^ advance;

  always_ff @(posedge clk) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_o;
  end

  assert_tog_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> tog_q != $past(tog_q));
  assert_tog_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act_i && !rd_start_i) |=> $stable(tog_q));
endmodule

// File: rtl/wcs_read_mux.sv
module wcs_read_mux
  import wcs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rd_mode_e          mode_i,
  input  logic              tog_i,
  input  logic              last_poll_i,
  input  logic [DATA_W-1:0] array_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_drive_o
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic [DATA_W-1:0] status_word;
  logic [DATA_W-1:0] next_data;

  always_comb begin
    status_word           = '0;
    status_word[POLL_BIT] = ~last_poll_i;
    status_word[TOG_BIT]  = tog_i;
    unique case (mode_i)
      MODE_TRUE:   next_data = array_i;
      MODE_STATUS: next_data = status_word;
      default:     next_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data_o  <= '0;
      rd_drive_o <= 1'b0;
    end else begin
      rd_data_o  <= next_data;
      rd_drive_o <= (mode_i != MODE_IDLE);
    end
  end

  assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_drive_o |-> rd_data_o == '0);
  assert_resv_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_STATUS) |=> rd_data_o[TOG_BIT-1:0] == '0);
  assert_poll_inv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_STATUS) |=> rd_data_o[POLL_BIT] == !$past(last_poll_i));
  assert_true_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_TRUE) |=> rd_data_o == $past(array_i));
endmodule

// File: rtl/wcs_responder.sv
module wcs_responder
  import wcs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              wr_load_i,
  input  logic [DATA_W-1:0] wr_byte_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_drive_o
);
  logic              rd_act, rd_start, tog;
  rd_mode_e          mode;
  logic [DATA_W-1:0] last_byte;

  wcs_strobe_track u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i),
    .busy_i(busy_i), .rd_act_o(rd_act), .rd_start_o(rd_start), .mode_o(mode)
  );

  wcs_last_byte #(.DATA_W(DATA_W)) u_last (
    .clk(clk), .rst_n(rst_n), .load_i(wr_load_i), .byte_i(wr_byte_i),
    .last_o(last_byte)
  );

  wcs_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .rd_start_i(rd_start), .rd_act_i(rd_act),
    .mode_i(mode), .tog_o(tog)
  );

  wcs_read_mux #(.DATA_W(DATA_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .tog_i(tog),
    .last_poll_i(last_byte[DATA_W-1]), .array_i(array_data_i),
    .rd_data_o(rd_data_o), .rd_drive_o(rd_drive_o)
  );

  assert_drive_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n_i && !oe_n_i) |=> rd_drive_o);
  assert_drive_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n_i || oe_n_i) |=> !rd_drive_o);
  assert_idle_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && !busy_i) |=> rd_data_o == $past(array_data_i));
endmodule

// File: tb/wcs_responder_test.sv
module wcs_responder_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busy = 1'b0, wl = 1'b0, ce_n = 1'b1, oe_n = 1'b1;
  logic [7:0] wb = '0, ad = '0;
  logic [7:0] rd_data;
  logic       rd_drive;

  int checks = 0, errors = 0, cycles = 0;

  // bench model state
  logic [7:0] m_last = '0;
  logic       m_tog = 1'b0, m_prev = 1'b0, m_stat = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wcs_responder uut (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .wr_load_i(wl), .wr_byte_i(wb),
    .ce_n_i(ce_n), .oe_n_i(oe_n), .array_data_i(ad),
    .rd_data_o(rd_data), .rd_drive_o(rd_drive)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic logic [7:0] status_of(input logic [7:0] last, input logic t);
    return {~last[7], t, 6'b0};
  endfunction

  // one cycle: apply inputs, predict, clock, compare
  task automatic step(input logic b, input logic c, input logic o, input logic l,
                      input logic [7:0] w, input logic [7:0] a);
    logic act, start, stat;
    logic [7:0] exp;
    busy = b; ce_n = c; oe_n = o; wl = l; wb = w; ad = a;
    act   = !c && !o;
    start = act && !m_prev;
    stat  = start ? b : m_stat;
    if (act && stat) begin
      if (start) m_tog = ~m_tog;
      exp = status_of(m_last, m_tog);
    end else if (act) exp = a;
    else exp = 8'h00;
    if (l) m_last = w;
    m_prev = act;
    m_stat = act ? stat : 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R2 drive", {7'b0, rd_drive}, {7'b0, act});
    if (!act) check("R2 idle data", rd_data, 8'h00);
    else if (stat) begin
      check("R4 poll bit", {7'b0, rd_data[7]}, {7'b0, exp[7]});
      check("R5 toggle bit", {7'b0, rd_data[6]}, {7'b0, exp[6]});
      check("R6 reserved", {2'b0, rd_data[5:0]}, 8'h00);
    end else check("R3 true data", rd_data, exp);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: got %0d cycles expected under 150000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset data", rd_data, 8'h00);
    check("R1 reset drive", {7'b0, rd_drive}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: plain read, not busy
    step(0, 0, 0, 0, 8'h00, 8'hA5);
    check("R3 directed", rd_data, 8'hA5);
    step(0, 1, 1, 0, 8'h00, 8'h00);
    // R9: load 0x3C, then start programming
    step(1, 1, 1, 1, 8'h3C, 8'h00);
    // R1: first status read after reset shows bit6=1, bit7=~0=1
    step(1, 0, 0, 0, 8'h00, 8'h3C);
    check("R1 first toggle", rd_data, 8'hC0);
    // R7: strobe held, bit 6 steady
    step(1, 0, 0, 0, 8'h00, 8'h3C);
    check("R7 held read", rd_data, 8'hC0);
    step(1, 0, 0, 0, 8'h00, 8'h3C);
    check("R7 held read 2", rd_data, 8'hC0);
    step(1, 1, 1, 0, 8'h00, 8'h00);
    // R5: next read flips bit 6
    step(1, 0, 0, 0, 8'h00, 8'h3C);
    check("R5 second read", rd_data, 8'h80);
    step(1, 1, 1, 0, 8'h00, 8'h00);
    // R2: chip selected but output disabled
    step(1, 0, 1, 0, 8'h00, 8'h3C);
    check("R2 oe high", {7'b0, rd_drive}, 8'h00);
    // R8: start busy, busy drops mid-access, access stays status
    step(1, 0, 0, 0, 8'h00, 8'h3C);
    check("R8 start status", rd_data, 8'hC0);
    step(0, 0, 0, 0, 8'h00, 8'h3C);
    check("R8 still status", rd_data, 8'hC0);
    step(0, 1, 1, 0, 8'h00, 8'h00);
    step(0, 0, 0, 0, 8'h00, 8'h3C);
    check("R8 true after end", rd_data, 8'h3C);
    step(0, 1, 1, 0, 8'h00, 8'h00);
    // R9 and R4: new byte with bit7=1 gives poll bit 0
    step(1, 1, 1, 1, 8'hC1, 8'h00);
    step(1, 0, 0, 0, 8'h00, 8'hC1);
    check("R9 R4 new last byte", rd_data, 8'h00);
    step(1, 1, 1, 0, 8'h00, 8'h00);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      logic b, c, o, l;
      b = ($urandom % 8) != 0 ? busy : ~busy;
      c = ($urandom % 4) == 0;
      o = ($urandom % 4) == 0;
      l = ($urandom % 6) == 0;
      step(b, c, o, l, 8'($urandom), 8'($urandom));
    end
    finish_run();
  end
endmodule